// File: doc/BRIEF.md
# RTC Alarm and Interrupt Status Unit

This unit sits beside the timekeeping logic of a real-time clock. It holds three alarm bytes for seconds, minutes and hours. On every update-complete strobe it compares them with the current time. An alarm byte of all ones acts as a wildcard and matches any value of its field.

The unit gathers three event sources: the alarm match, a periodic tick and the update-complete strobe. Each source sets its own sticky flag, whether or not that source is enabled. A summary request flag is raised only when a pending flag meets its enable. All four flags appear in one status byte. The interrupt request line follows the summary flag. Reading the status byte clears every flag, which re-arms the interrupt path. An event that lands in the same cycle as the read is carried into the next status value.

Top module: `rtc_irq_status`

## Requirements
- R1: After reset the status byte is 0x00, `irq` is low, and all three alarm bytes are 0x00.
- R2: A write with `reg_wr` high stores `reg_wdata` as the alarm seconds at address 1, the alarm minutes at address 3 and the alarm hours at address 5. A write to any other address leaves all alarm bytes unchanged.
- R3: When `upd_done` is high and each alarm byte equals 0xFF or equals its current time byte, the alarm flag (status bit 5) reads 1 from the next cycle on.
- R4: The alarm flag is never set in a cycle without `upd_done`, even when the current time matches the alarm bytes.
- R5: `per_tick` sets the periodic flag (status bit 6) and `upd_done` sets the update flag (status bit 4) in the next cycle, whatever the enable inputs are.
- R6: The request flag (status bit 7) becomes 1 only when a pending flag has its enable high (`en_per` for bit 6, `en_alm` for bit 5, `en_upd` for bit 4). Status bits 3 to 0 always read 0.
- R7: `irq` equals status bit 7. Once high, it stays high until a status read.
- R8: A cycle with `rd_status` high clears all four flags in the next cycle, unless an event arrives in that same cycle.
- R9: An event that arrives in the same cycle as `rd_status` sets its flag, and the request flag if that flag is enabled, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Alarm register write strobe |
| reg_addr | input | 6 | Register address for writes |
| reg_wdata | input | 8 | Write data |
| rd_status | input | 1 | One-cycle strobe: status byte is being read |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| upd_done | input | 1 | Update-complete strobe, once per second |
| per_tick | input | 1 | Periodic event strobe |
| en_per | input | 1 | Periodic interrupt enable |
| en_alm | input | 1 | Alarm interrupt enable |
| en_upd | input | 1 | Update interrupt enable |
| status | output | 8 | Status byte {request, periodic, alarm, update, 0000} |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives events in the same cycle as a status read. A design that cleared after merging would lose those events, and R9 would show it. It also holds a matching time without the update strobe. A comparator that was not gated would set the alarm flag on every cycle. Wildcard patterns and writes to neighbouring addresses are mixed in: a wrong wildcard test misses the every-minute alarm, and a loose address decode corrupts an alarm byte. The bench also turns enables on while a flag is pending and turns them off while the request is high. This exposes a request flag that is not sticky, or one that is set without an enable.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    typedef struct packed {
        logic irqf;
        logic pf;
        logic af;
        logic uf;
    } irq_flags_t;

    localparam int unsigned FLD_SEC = 0;
    localparam int unsigned FLD_MIN = 1;
    localparam int unsigned FLD_HR  = 2;
    localparam int unsigned NUM_FLD = 3;

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_irq_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned SEC_ADDR = 1,
    parameter int unsigned MIN_ADDR = 3,
    parameter int unsigned HR_ADDR  = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [NUM_FLD*DATA_W-1:0]   alarm_flat
);

    logic [DATA_W-1:0] alm_d [NUM_FLD];
    logic [DATA_W-1:0] alm_q [NUM_FLD];

    for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
        localparam int unsigned FLD_ADDR = (g == FLD_SEC) ? SEC_ADDR :
                                           (g == FLD_MIN) ? MIN_ADDR : HR_ADDR;
        localparam logic [ADDR_W-1:0] FLD_A = ADDR_W'(FLD_ADDR);

        always_comb begin
            alm_d[g] = alm_q[g];
            if (wr_en && (wr_addr == FLD_A)) begin
                alm_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                alm_q[g] <= '0;
            end else begin
                alm_q[g] <= alm_d[g];
            end
        end

        assign alarm_flat[g*DATA_W +: DATA_W] = alm_q[g];
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [NUM_FLD*DATA_W-1:0] alarm_flat,
    input  logic [NUM_FLD*DATA_W-1:0] time_flat,
    input  logic                      upd,
    output logic                      hit
);

    localparam logic [DATA_W-1:0] WILDCARD = '1;

    logic [NUM_FLD-1:0] fld_ok;

    for (genvar g = 0; g < NUM_FLD; g++) begin : g_cmp
        logic [DATA_W-1:0] alm_b;
        logic [DATA_W-1:0] cur_b;
        assign alm_b     = alarm_flat[g*DATA_W +: DATA_W];
        assign cur_b     = time_flat[g*DATA_W +: DATA_W];
        assign fld_ok[g] = (alm_b == WILDCARD) || (alm_b == cur_b);
    end

    assign hit = upd && (&fld_ok);

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  logic       per_ev,
    input  logic       alm_ev,
    input  logic       upd_ev,
    input  logic       en_per,
    input  logic       en_alm,
    input  logic       en_upd,
    output irq_flags_t flags
);

    irq_flags_t fl_d;
    irq_flags_t fl_q;

    always_comb begin
        logic keep;
        keep    = !rd;
        fl_d.pf = per_ev || (fl_q.pf && keep);
        fl_d.af = alm_ev || (fl_q.af && keep);
        fl_d.uf = upd_ev || (fl_q.uf && keep);
        fl_d.irqf = (fl_q.irqf && keep)
                  || (fl_d.pf && en_per)
                  || (fl_d.af && en_alm)
                  || (fl_d.uf && en_upd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;

endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
    import rtc_irq_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned SEC_ADDR = 1,
    parameter int unsigned MIN_ADDR = 3,
    parameter int unsigned HR_ADDR  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              rd_status,
    input  logic [DATA_W-1:0] cur_sec,
    input  logic [DATA_W-1:0] cur_min,
    input  logic [DATA_W-1:0] cur_hour,
    input  logic              upd_done,
    input  logic              per_tick,
    input  logic              en_per,
    input  logic              en_alm,
    input  logic              en_upd,
    output logic [DATA_W-1:0] status,
    output logic              irq
);

    localparam int unsigned FLAT_W = NUM_FLD * DATA_W;
    localparam int unsigned PAD_W  = DATA_W - 4;

    logic [FLAT_W-1:0] alarm_flat;
    logic [FLAT_W-1:0] time_flat;
    logic              alarm_hit;
    irq_flags_t        flags;

    assign time_flat = {cur_hour, cur_min, cur_sec};

    rtc_alarm_regs #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .SEC_ADDR (SEC_ADDR),
        .MIN_ADDR (MIN_ADDR),
        .HR_ADDR  (HR_ADDR)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .alarm_flat (alarm_flat)
    );

    rtc_alarm_match #(
        .DATA_W (DATA_W)
    ) match_i (
        .alarm_flat (alarm_flat),
        .time_flat  (time_flat),
        .upd        (upd_done),
        .hit        (alarm_hit)
    );

    rtc_irq_flags flags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (rd_status),
        .per_ev (per_tick),
        .alm_ev (alarm_hit),
        .upd_ev (upd_done),
        .en_per (en_per),
        .en_alm (en_alm),
        .en_upd (en_upd),
        .flags  (flags)
    );

    assign status = {flags.irqf, flags.pf, flags.af, flags.uf, {PAD_W{1'b0}}};
    assign irq    = flags.irqf;

endmodule

// File: rtl/rtc_irq_status_chk.sv
module rtc_irq_status_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_status,
    input logic              upd_done,
    input logic              per_tick,
    input logic              en_per,
    input logic              en_alm,
    input logic              en_upd,
    input logic [DATA_W-1:0] status,
    input logic              irq
);

    a_r4_alarm_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !$past(status[5])) |-> $past(upd_done));

    a_r5_periodic_latches: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick |=> status[6]);

    a_r9_update_kept_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && rd_status) |=> status[4]);

    a_r6_request_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[7]) |-> ((status[6] && $past(en_per)) ||
                              (status[5] && $past(en_alm)) ||
                              (status[4] && $past(en_upd))));

    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_status) |=> irq);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !per_tick && !upd_done) |=> (status[7:4] == 4'b0 && !irq));

endmodule

bind rtc_irq_status rtc_irq_status_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_status (rd_status),
    .upd_done  (upd_done),
    .per_tick  (per_tick),
    .en_per    (en_per),
    .en_alm    (en_alm),
    .en_upd    (en_upd),
    .status    (status),
    .irq       (irq)
);

// File: tb/rtc_irq_status_tb_top.sv
`timescale 1ns/1ps
module rtc_irq_status_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       rd_status;
    logic [7:0] cur_sec, cur_min, cur_hour;
    logic       upd_done, per_tick;
    logic       en_per, en_alm, en_upd;
    logic [7:0] status;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_alm [3];
    logic [3:0] m_fl;

    always #5 clk = ~clk;

    rtc_irq_status dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_status(rd_status), .cur_sec(cur_sec),
        .cur_min(cur_min), .cur_hour(cur_hour), .upd_done(upd_done),
        .per_tick(per_tick), .en_per(en_per), .en_alm(en_alm),
        .en_upd(en_upd), .status(status), .irq(irq)
    );

    function automatic logic [3:0] flags_next(logic [3:0] f, logic rd, logic per,
                                              logic hit, logic upd, logic ep,
                                              logic ea, logic eu);
        logic [3:0] n;
        n[2] = per | (f[2] & ~rd);
        n[1] = hit | (f[1] & ~rd);
        n[0] = upd | (f[0] & ~rd);
        n[3] = (f[3] & ~rd) | (n[2] & ep) | (n[1] & ea) | (n[0] & eu);
        return n;
    endfunction

    function automatic logic alarm_hit(logic [7:0] s, logic [7:0] m, logic [7:0] h);
        logic ok;
        ok = (m_alm[0] == 8'hFF || m_alm[0] == s) &&
             (m_alm[1] == 8'hFF || m_alm[1] == m) &&
             (m_alm[2] == 8'hFF || m_alm[2] == h);
        return ok;
    endfunction

    task automatic check(string tag);
        checks++;
        if (status !== {m_fl, 4'b0000}) begin
            failures++;
            $display("FAIL %s status actual=%02h expected=%02h", tag, status, {m_fl, 4'b0000});
        end
        checks++;
        if (irq !== m_fl[3]) begin
            failures++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, m_fl[3]);
        end
    endtask

    // inputs are already set; advance model and one clock, then compare
    task automatic step(string tag);
        logic hit;
        hit  = upd_done && alarm_hit(cur_sec, cur_min, cur_hour);
        m_fl = flags_next(m_fl, rd_status, per_tick, hit, upd_done, en_per, en_alm, en_upd);
        if (reg_wr) begin
            if (reg_addr == 6'd1) m_alm[0] = reg_wdata;
            if (reg_addr == 6'd3) m_alm[1] = reg_wdata;
            if (reg_addr == 6'd5) m_alm[2] = reg_wdata;
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle();
        reg_wr = 0; rd_status = 0; upd_done = 0; per_tick = 0;
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d, string tag);
        idle(); reg_wr = 1; reg_addr = a; reg_wdata = d;
        step(tag);
        reg_wr = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; idle(); reg_addr = 0; reg_wdata = 0;
        cur_sec = 0; cur_min = 0; cur_hour = 0;
        en_per = 0; en_alm = 0; en_upd = 0;
        for (int i = 0; i < 3; i++) m_alm[i] = 8'h00;
        m_fl = 4'b0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset state");

        // R1: alarm bytes reset to zero, so 00:00:00 with update matches
        upd_done = 1; step("R1 reset alarm value matches 00:00:00");
        idle(); rd_status = 1; step("R8 read clears flags");
        idle();

        // R2: program every-minute pattern FF:FF:00, decoy write to address 2
        wr(6'd1, 8'h00, "R2 write alarm seconds");
        wr(6'd3, 8'hFF, "R2 write alarm minutes");
        wr(6'd5, 8'hFF, "R2 write alarm hours");
        wr(6'd2, 8'h12, "R2 write to other address ignored");
        wr(6'd0, 8'h34, "R2 write to other address ignored");

        // R4: matching time without update strobe
        cur_hour = 8'h12; cur_min = 8'h34; cur_sec = 8'h00;
        step("R4 no alarm without update");
        step("R4 no alarm without update");
        // R3: wildcard match on update
        upd_done = 1; step("R3 wildcard alarm fires");
        idle(); cur_sec = 8'h01; rd_status = 1; step("R8 read clears alarm");
        idle(); upd_done = 1; step("R3 non matching second gives no alarm");
        idle(); rd_status = 1; step("R8 read clears");

        // R5 / R6: flags latch without enables, request needs enable
        idle(); per_tick = 1; step("R5 periodic latches without enable");
        idle(); step("R6 no request without enable");
        en_per = 1; step("R6 enable on pending flag raises request");
        en_per = 0; step("R7 irq held after enable drops");
        step("R7 irq held");
        // R9: event coincides with read
        rd_status = 1; upd_done = 1; en_upd = 1; step("R9 event kept across read");
        idle(); en_upd = 0; rd_status = 1; step("R8 read clears all");
        idle(); rd_status = 1; per_tick = 1; step("R9 periodic kept across read");
        idle(); rd_status = 1; step("R8 clear");

        // FF:00:FF pattern: every second in the first minute of each hour
        wr(6'd1, 8'hFF, "R2 seconds wildcard");
        wr(6'd3, 8'h00, "R2 minutes zero");
        en_alm = 1;
        cur_min = 8'h00; cur_sec = 8'h17; upd_done = 1; step("R3 first minute fires");
        idle(); rd_status = 1; step("R8 clear");
        idle(); cur_min = 8'h01; upd_done = 1; step("R3 second minute silent");
        idle(); rd_status = 1; step("R8 clear");
        idle();

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            idle();
            reg_wr    = ($urandom_range(0, 15) == 0);
            reg_addr  = 6'($urandom_range(0, 7));
            reg_wdata = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 3));
            rd_status = ($urandom_range(0, 5) == 0);
            upd_done  = ($urandom_range(0, 3) == 0);
            per_tick  = ($urandom_range(0, 4) == 0);
            cur_sec   = 8'($urandom_range(0, 3));
            cur_min   = 8'($urandom_range(0, 3));
            cur_hour  = 8'($urandom_range(0, 3));
            if ($urandom_range(0, 7) == 0) begin
                en_per = 1'($urandom); en_alm = 1'($urandom); en_upd = 1'($urandom);
            end
            step("R3 R5 R6 R7 R9 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule